// File: doc/BRIEF.md
# Double-Bank Shifting Transpose Buffer

This block sits between a stage that produces one row of a square block per cycle and a stage that consumes one column per cycle. It holds two register banks of N×N words. While one bank takes in the rows of the current block, the other bank hands out the columns of the block before it. The banks change roles each time the last row of a block arrives. Incoming rows can be accepted on every cycle, with no stall.

No addresses are generated. A write shifts the whole bank down by one row and puts the new row at the top. A read presents the rightmost column and shifts every column one place right, with zeros entering on the left. The write-side demultiplexer select and the read-side multiplexer select are held in separate registers that always disagree. A bank is given back to the writer only after all of its columns have been read out.

Top module: `transpose_pingpong`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `col_valid` is low. The first block is written into bank A.
- R2: `col_valid` first rises on the cycle after the N-th accepted row is captured. It is never high before a whole block has been accepted.
- R3: While `col_valid` is high, the k-th column emitted for a block has element i at bits `[i*W +: W]`, equal to row i, element k of that block. Row element j is taken from `row_data[j*W +: W]`.
- R4: Blocks sent back to back are emitted back to back. Every column of block b holds only data from block b.
- R5: Each block produces exactly N cycles of `col_valid`, one per column. Every run of `col_valid` is a whole multiple of N. With no further complete block, `col_valid` returns low.
- R6: On a cycle where `row_valid` is low, `row_data` is ignored and no row is counted. Blocks sent with idle cycles between rows come out unchanged.
- R7: The write-bank select and the read-bank select are always complementary. Both toggle when the N-th row of a block is accepted.
- R8: A bank is never written and read in the same cycle. A swap happens only when the read bank is idle or is presenting its last column.
- R9: Full-width values (0xFFFF, 0x8000, 0x0001) pass through bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| row_valid | input | 1 | Qualifies `row_data` this cycle |
| row_data | input | N*W (256) | One row, element j at bits `[j*W +: W]` |
| col_valid | output | 1 | A column is presented on `col_data` |
| col_data | output | N*W (256) | One column, element i (row i) at bits `[i*W +: W]` |

## Verification
The bench drives six consecutive blocks and checks every column word against a pattern computed from the block, row and column indices. Four of the blocks are sent back to back. A column order that is reversed or mirrored, or a bank swap that comes one cycle late, shows up as words taken from the wrong block or the wrong position.

Idle stretches with garbage on `row_data` and a low `row_valid` come next, followed by blocks sent with a gap before each row. A design that counts invalid rows loses block alignment. A design that lets the read drain in lock-step with the writes stretches or splits the N-cycle output bursts, which the run-length checks catch.

An early `col_valid` before the first full block is reported as a failure. So is a missing rise on the cycle right after the N-th row.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // mirror an index inside a dimension of size n
  function automatic int unsigned mirror_idx(int unsigned i, int unsigned n);
    return n - 1 - i;
  endfunction

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/tpose_ctrl.sv
module tpose_ctrl
  import tpose_pkg::*;
#(
  parameter int N = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  row_valid,
  output bank_e wr_bank,
  output bank_e rd_bank,
  output logic  rd_active,
  output logic  swap
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] wcnt;
  logic [CW-1:0] rcnt;
  logic          primed;
  logic          rd_last;

  assign swap    = row_valid && (wcnt == LAST);
  assign rd_last = rd_active && (rcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      rcnt      <= '0;
      wr_bank   <= BANK_A;
      rd_bank   <= BANK_B;
      rd_active <= 1'b0;
      primed    <= 1'b0;
    end else begin
      if (row_valid) begin
        wcnt <= swap ? '0 : wcnt + 1'b1;
      end
      if (swap) begin
        wr_bank   <= other_bank(wr_bank);
        rd_bank   <= other_bank(rd_bank);
        rd_active <= 1'b1;
        rcnt      <= '0;
        primed    <= 1'b1;
      end else if (rd_active) begin
        rcnt <= rcnt + 1'b1;
        if (rd_last) begin
          rd_active <= 1'b0;
        end
      end
    end
  end

  // R7
  sel_compl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_bank != rd_bank);

  // R7
  sel_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    swap |=> (wr_bank != $past(wr_bank)));

  // R8
  reuse_drained_chk: assert property (@(posedge clk) disable iff (rst)
    swap |-> (!rd_active || rd_last));

  // R2
  no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
    !primed |-> !rd_active);

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_active) |-> $past(rd_last));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !row_valid |=> $stable(wcnt));

endmodule

// File: rtl/tpose_bank.sv
module tpose_bank
  import tpose_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N*W-1:0] wr_row,
  input  logic         rd_en,
  output logic [N*W-1:0] rd_col
);
  logic [W-1:0] mem [N][N];

  // write: new row enters at the top, older rows slide down;
  // element j lands in the mirrored column so element 0 is read first.
  // read: columns slide right, zeros enter on the left.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int p = 0; p < N; p++) begin
        for (int q = 0; q < N; q++) begin
          if (p == 0) begin
            mem[0][q] <= wr_row[mirror_idx(q, N)*W +: W];
          end else begin
            mem[p][q] <= mem[p-1][q];
          end
        end
      end
    end else if (rd_en) begin
      for (int p = 0; p < N; p++) begin
        for (int q = 0; q < N; q++) begin
          if (q == 0) begin
            mem[p][0] <= '0;
          end else begin
            mem[p][q] <= mem[p][q-1];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rd_col[i*W +: W] = mem[mirror_idx(i, N)][N-1];
    end
  end

  // R8
  bank_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

endmodule

// File: rtl/transpose_pingpong.sv
module transpose_pingpong
  import tpose_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           row_valid,
  input  logic [N*W-1:0] row_data,
  output logic           col_valid,
  output logic [N*W-1:0] col_data
);
  localparam int NB = 2;

  bank_e          wr_bank;
  bank_e          rd_bank;
  logic           rd_active;
  logic           swap;
  logic [NB-1:0]  bank_wr_en;
  logic [NB-1:0]  bank_rd_en;
  logic [N*W-1:0] bank_col [NB];

  tpose_ctrl #(.N(N)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .row_valid (row_valid),
    .wr_bank   (wr_bank),
    .rd_bank   (rd_bank),
    .rd_active (rd_active),
    .swap      (swap)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_wr_en[b] = row_valid && (wr_bank == bank_e'(b));
    assign bank_rd_en[b] = rd_active && (rd_bank == bank_e'(b));

    tpose_bank #(.N(N), .W(W)) bank_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bank_wr_en[b]),
      .wr_row (row_data),
      .rd_en  (bank_rd_en[b]),
      .rd_col (bank_col[b])
    );
  end

  assign col_valid = rd_active;
  assign col_data  = (rd_bank == BANK_B) ? bank_col[1] : bank_col[0];

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_wr_en) && $onehot0(bank_rd_en));

  // R4
  continuous_chk: assert property (@(posedge clk) disable iff (rst)
    (swap && rd_active) |=> col_valid);

endmodule

// File: tb/transpose_pingpong_tb.sv
module transpose_pingpong_tb_top;
  localparam int  N = 16;
  localparam int  W = 16;
  localparam time CLK_PERIOD = 10;
  localparam int  NBLK = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           row_valid = 1'b0;
  logic [N*W-1:0] row_data = '0;
  logic           col_valid;
  logic [N*W-1:0] col_data;

  int checks = 0;
  int fails = 0;
  int rows_acc = 0;
  int out_blk = 0;
  int out_col = 0;
  int run = 0;
  bit prev_v = 1'b0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  transpose_pingpong #(.N(N), .W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .row_valid (row_valid),
    .row_data  (row_data),
    .col_valid (col_valid),
    .col_data  (col_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] pat(int b, int r, int c);
    if (b == 3) begin
      case ((r + c) % 3)
        0:       return 16'hFFFF;
        1:       return 16'h8000;
        default: return 16'h0001;
      endcase
    end
    return 16'(b * 4096 + r * 256 + c * 16 + ((r ^ c) & 15));
  endfunction

  task automatic send_block(int b, bit gappy);
    for (int r = 0; r < N; r++) begin
      if (gappy) begin
        @(negedge clk);
        row_valid = 1'b0;
        row_data  = {N{16'hDEAD}};
      end
      @(negedge clk);
      row_valid = 1'b1;
      for (int c = 0; c < N; c++) row_data[c*W +: W] = pat(b, r, c);
      @(posedge clk);
      #1 rows_acc++;
    end
  endtask

  task automatic idle(int cycles, int check_from);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      row_valid = 1'b0;
      row_data  = {N{16'hBEEF}} ^ N*W'(k);
      if (k >= check_from) begin
        #1;
        checks++;
        if (col_valid !== 1'b0) begin
          fails++;
          $display("FAIL R6 idle col_valid actual=%b expected=0", col_valid);
        end
      end
    end
  endtask

  // column monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (col_valid) begin
        if (out_col == 0) begin
          checks++;  // R2: block must be fully accepted
          if ((out_blk + 1) * N > rows_acc) begin
            fails++;
            $display("FAIL R2 early column rows_acc actual=%0d expected>=%0d",
                     rows_acc, (out_blk + 1) * N);
          end
        end
        begin
          bit ok;
          int bad_i;
          ok = 1'b1;
          bad_i = 0;
          for (int i = 0; i < N; i++) begin
            if (ok && col_data[i*W +: W] !== pat(out_blk, i, out_col)) begin
              ok = 1'b0;
              bad_i = i;
            end
          end
          checks++;
          if (!ok) begin
            fails++;
            $display("FAIL %s blk %0d col %0d elem %0d actual=%h expected=%h",
                     (out_blk == 3) ? "R9" : "R3,R4", out_blk, out_col, bad_i,
                     col_data[bad_i*W +: W], pat(out_blk, bad_i, out_col));
          end
        end
        run++;
        out_col++;
        if (out_col == N) begin
          out_col = 0;
          out_blk++;
        end
      end else if (prev_v) begin
        checks++;  // R5: bursts are whole blocks
        if (run % N != 0) begin
          fails++;
          $display("FAIL R5 burst length actual=%0d expected multiple of %0d", run, N);
        end
        run = 0;
      end
      prev_v = col_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1
    if (col_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset col_valid actual=%b expected=0", col_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1
    if (col_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset col_valid actual=%b expected=0", col_valid);
    end
    mon_en = 1'b1;

    send_block(0, 1'b0);
    checks++;  // R2: rises right after the N-th row
    if (col_valid !== 1'b1) begin
      fails++;
      $display("FAIL R2 col_valid after row %0d actual=%b expected=1", N, col_valid);
    end
    send_block(1, 1'b0);
    send_block(2, 1'b0);
    send_block(3, 1'b0);
    idle(40, N + 2);      // R6: garbage with row_valid low
    send_block(4, 1'b1);  // R6: gaps between rows
    send_block(5, 1'b1);
    idle(50, N + 4);

    checks++;  // R5
    if (out_blk != NBLK || out_col != 0) begin
      fails++;
      $display("FAIL R5 columns out actual=%0d expected=%0d",
               out_blk * N + out_col, NBLK * N);
    end
    checks++;  // R5
    if (col_valid !== 1'b0) begin
      fails++;
      $display("FAIL R5 final col_valid actual=%b expected=0", col_valid);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule